// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block carries out one read or one write at a time on the parallel control-register port of a serial-link PHY. A host presents a command with a direction, a PHY index, a register address and, for writes, a data word. The block then drives the selected PHY's port through a four-phase request/acknowledge exchange. It raises an enable, polls for the acknowledge to go high, drops the enable, and polls for the acknowledge to go low. When the exchange ends it returns read data, a one-cycle completion pulse and a timeout report.

Several PHYs hang off the block. Each has its own select, enable and acknowledge lines and its own read-data bus. Address and write data are shared buses. The select line of a PHY is raised the first time that PHY is addressed. It then stays up, and the block lets a settle interval pass before the first enable. Each acknowledge wait has a bounded budget of samples spaced a fixed number of cycles apart. When the budget runs out, the transaction is abandoned with a timeout cause that says which direction and which edge failed.

Top module: `phy_cr_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls: `cmd_ready` is 1; `rsp_done`, `rsp_timeout`, `rsp_cause` and every bit of `phy_sel`, `phy_wr_en` and `phy_rd_en` are 0.
- R2: A write drives `phy_addr` first, then `phy_wdata` one cycle later, then raises the target's `phy_wr_en` one cycle after that. Address and data hold steady while an enable is high.
- R3: A write keeps `phy_wr_en` high until acknowledge is seen high and then drops it. It pulses `rsp_done` after acknowledge is seen low, and the PHY has then stored the data.
- R4: A read raises `phy_rd_en` right after driving the address. It captures the target's read-data bus in the sample where acknowledge is first seen high, drops `phy_rd_en`, and presents the captured word on `rsp_rdata` with `rsp_done`.
- R5: Acknowledge is sampled once every POLL_GAP cycles, at most POLL_LIMIT times per wait (defaults 16 and 10). An acknowledge that arrives within that budget completes with `rsp_timeout` = 0.
- R6: If acknowledge is not seen high within the budget, the transaction ends with `rsp_done` and `rsp_timeout` = 1. `rsp_cause` is 2'b10 for a write and 2'b00 for a read: bit 1 = write, bit 0 = falling-edge wait.
- R7: If acknowledge is not seen low within the budget after the enable drops, the transaction ends with `rsp_timeout` = 1 and `rsp_cause` 2'b11 for a write or 2'b01 for a read. Data already captured by a read is still returned.
- R8: At most one enable bit is high at any time. All enables are low in the cycle `rsp_done` is high, timeouts included.
- R9: A PHY's `phy_sel` bit rises on the first command to that PHY and stays high until reset. An enable to that PHY rises only after its select has been high for at least POLL_GAP cycles.
- R10: `cmd_ready` is high only when idle. A command offered while `cmd_ready` is low is dropped and changes no PHY register.
- R11: Each command reaches only the PHY named by `cmd_phy`. Registers of different PHYs at the same address hold independent values.
- R12: `rsp_done` is high for exactly one cycle per transaction. `rsp_timeout` and `rsp_cause` hold their values until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_phy | input | PHY_W | Target PHY index |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data returned by the last read |
| rsp_timeout | output | 1 | Last transaction ran out of polls |
| rsp_cause | output | 2 | Timeout cause: bit 1 write, bit 0 falling-edge wait |
| phy_sel | output | NUM_PHY | Per-PHY port select |
| phy_addr | output | ADDR_W | Shared register address bus |
| phy_wdata | output | DATA_W | Shared write-data bus |
| phy_wr_en | output | NUM_PHY | Per-PHY write enable |
| phy_rd_en | output | NUM_PHY | Per-PHY read enable |
| phy_ack | input | NUM_PHY | Per-PHY acknowledge |
| phy_rdata | input | NUM_PHY*DATA_W | Per-PHY read data, PHY 0 in the low bits |

## Verification
The hardest case to reach is a falling-edge timeout. The PHY must have answered the request, so the rising edge passed, and must then hold acknowledge high after the enable drops. Only after that does the block count down its second budget. The bench PHY model has separate switches that suppress the rise or the fall of acknowledge. This gives all four timeout causes, and the model can then be released so later transactions show that the block recovers. A command offered mid-transaction is applied by hand while a slow PHY holds the block busy. The dropped write is then shown to have no effect by reading its address back.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_DATA,
    ST_ENA,
    ST_RISE,
    ST_FALL
  } cr_state_e;

  // Cause code: bit 1 = write transaction, bit 0 = waiting for the falling edge
  function automatic logic [1:0] mk_cause(input logic is_write, input logic is_fall);
    return {is_write, is_fall};
  endfunction

endpackage

// File: rtl/phy_cr_poll_timer.sv
module phy_cr_poll_timer #(
  parameter int GAP   = 16,
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic sample,
  output logic last
);
  localparam int GW = $clog2(GAP + 1);
  localparam int PW = $clog2(LIMIT + 1);

  logic [GW-1:0] gap_q;
  logic [PW-1:0] polls_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      gap_q   <= GW'(GAP - 1);
      polls_q <= '0;
    end else if (run) begin
      if (gap_q == '0) begin
        gap_q <= GW'(GAP - 1);
        if (polls_q != PW'(LIMIT)) polls_q <= polls_q + 1'b1;
      end else begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end

  assign sample = run && (gap_q == '0);
  assign last   = (polls_q >= PW'(LIMIT - 1));

endmodule

// File: rtl/phy_cr_port_mux.sv
module phy_cr_port_mux #(
  parameter int NUM_PHY = 2,
  parameter int DATA_W  = 16,
  localparam int PHY_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic [PHY_W-1:0]          idx,
  input  logic [NUM_PHY-1:0]        ack_vec,
  input  logic [NUM_PHY*DATA_W-1:0] rdata_flat,
  output logic                      ack,
  output logic [DATA_W-1:0]         rdata
);
  logic [DATA_W-1:0] rd_arr [NUM_PHY];

  for (genvar i = 0; i < NUM_PHY; i++) begin : g_lane
    assign rd_arr[i] = rdata_flat[i*DATA_W +: DATA_W];
  end

  assign ack   = ack_vec[idx];
  assign rdata = rd_arr[idx];

endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int NUM_PHY    = 2,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int POLL_GAP   = 16,
  parameter int POLL_LIMIT = 10,
  localparam int PHY_W     = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic                      cmd_write,
  input  logic [PHY_W-1:0]          cmd_phy,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic [DATA_W-1:0]         cmd_wdata,
  output logic                      rsp_done,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_timeout,
  output logic [1:0]                rsp_cause,
  output logic [NUM_PHY-1:0]        phy_sel,
  output logic [ADDR_W-1:0]         phy_addr,
  output logic [DATA_W-1:0]         phy_wdata,
  output logic [NUM_PHY-1:0]        phy_wr_en,
  output logic [NUM_PHY-1:0]        phy_rd_en,
  input  logic [NUM_PHY-1:0]        phy_ack,
  input  logic [NUM_PHY*DATA_W-1:0] phy_rdata
);

  cr_state_e         state_q;
  logic              wr_q;
  logic [PHY_W-1:0]  phy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic              ack_cur;
  logic [DATA_W-1:0] rdata_cur;
  logic              accept;
  logic              tmr_start, tmr_run, tick, last_poll;

  phy_cr_port_mux #(
    .NUM_PHY (NUM_PHY),
    .DATA_W  (DATA_W)
  ) mux_i (
    .idx        (phy_q),
    .ack_vec    (phy_ack),
    .rdata_flat (phy_rdata),
    .ack        (ack_cur),
    .rdata      (rdata_cur)
  );

  assign accept    = cmd_valid && (state_q == ST_IDLE);
  assign tmr_run   = (state_q == ST_SEL) || (state_q == ST_RISE) || (state_q == ST_FALL);
  assign tmr_start = (accept && !phy_sel[cmd_phy])
                   || (state_q == ST_ENA)
                   || ((state_q == ST_RISE) && tick && ack_cur);

  phy_cr_poll_timer #(
    .GAP   (POLL_GAP),
    .LIMIT (POLL_LIMIT)
  ) tmr_i (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .run    (tmr_run),
    .sample (tick),
    .last   (last_poll)
  );

  assign cmd_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      phy_q       <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rsp_done    <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
      rsp_cause   <= 2'b00;
      phy_sel     <= '0;
      phy_addr    <= '0;
      phy_wdata   <= '0;
      phy_wr_en   <= '0;
      phy_rd_en   <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            wr_q        <= cmd_write;
            phy_q       <= cmd_phy;
            addr_q      <= cmd_addr;
            wdata_q     <= cmd_wdata;
            rsp_timeout <= 1'b0;
            rsp_cause   <= 2'b00;
            if (phy_sel[cmd_phy]) begin
              state_q <= ST_ADDR;
            end else begin
              phy_sel[cmd_phy] <= 1'b1;
              state_q          <= ST_SEL;
            end
          end
        end
        ST_SEL: begin
          if (tick) state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          phy_addr <= addr_q;
          state_q  <= wr_q ? ST_DATA : ST_ENA;
        end
        ST_DATA: begin
          phy_wdata <= wdata_q;
          state_q   <= ST_ENA;
        end
        ST_ENA: begin
          if (wr_q) phy_wr_en[phy_q] <= 1'b1;
          else      phy_rd_en[phy_q] <= 1'b1;
          state_q <= ST_RISE;
        end
        ST_RISE: begin
          if (tick) begin
            if (ack_cur) begin
              if (!wr_q) rsp_rdata <= rdata_cur;
              phy_wr_en <= '0;
              phy_rd_en <= '0;
              state_q   <= ST_FALL;
            end else if (last_poll) begin
              phy_wr_en   <= '0;
              phy_rd_en   <= '0;
              rsp_timeout <= 1'b1;
              rsp_cause   <= mk_cause(wr_q, 1'b0);
              rsp_done    <= 1'b1;
              state_q     <= ST_IDLE;
            end
          end
        end
        ST_FALL: begin
          if (tick) begin
            if (!ack_cur) begin
              rsp_done <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (last_poll) begin
              rsp_timeout <= 1'b1;
              rsp_cause   <= mk_cause(wr_q, 1'b1);
              rsp_done    <= 1'b1;
              state_q     <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int NUM_PHY = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_ready,
  input logic               rsp_done,
  input logic               rsp_timeout,
  input logic [NUM_PHY-1:0] phy_sel,
  input logic [NUM_PHY-1:0] phy_wr_en,
  input logic [NUM_PHY-1:0] phy_rd_en,
  input logic [ADDR_W-1:0]  phy_addr,
  input logic [DATA_W-1:0]  phy_wdata
);

  // R8
  en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({phy_wr_en, phy_rd_en}));

  // R8
  en_low_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> ((phy_wr_en | phy_rd_en) == '0));

  // R9
  sel_before_en_chk: assert property (@(posedge clk) disable iff (rst)
    ((phy_wr_en | phy_rd_en) & ~phy_sel) == '0);

  // R9
  sel_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(phy_sel) & ~phy_sel) == '0);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (|(phy_wr_en | phy_rd_en)) |-> !cmd_ready);

  // R2
  bus_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (|(phy_wr_en | phy_rd_en)) |-> ($stable(phy_addr) && $stable(phy_wdata)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R12
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_timeout) |-> rsp_done);

endmodule

bind phy_cr_master phy_cr_master_chk #(
  .NUM_PHY (NUM_PHY),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cmd_ready   (cmd_ready),
  .rsp_done    (rsp_done),
  .rsp_timeout (rsp_timeout),
  .phy_sel     (phy_sel),
  .phy_wr_en   (phy_wr_en),
  .phy_rd_en   (phy_rd_en),
  .phy_addr    (phy_addr),
  .phy_wdata   (phy_wdata)
);

// File: tb/phy_cr_master_tb_top.sv
module phy_cr_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPHY = 2;
  localparam int AW   = 16;
  localparam int DW   = 16;
  localparam int GAP  = 16;
  localparam int VW   = 1 + 1 + AW + DW + DW;
  localparam int NVEC = 7;

  // {write, phy, addr, wdata, expected read data}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'h0003, 16'h1111, 16'h0000},
    {1'b1, 1'b1, 16'h0003, 16'h2222, 16'h0000},
    {1'b0, 1'b0, 16'h0003, 16'h0000, 16'h1111},
    {1'b0, 1'b1, 16'h0003, 16'h0000, 16'h2222},
    {1'b1, 1'b1, 16'h0007, 16'hABCD, 16'h0000},
    {1'b0, 1'b1, 16'h0007, 16'h0000, 16'hABCD},
    {1'b0, 1'b0, 16'h0005, 16'h0000, 16'hA005}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [0:0] cmd_phy = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_done, rsp_timeout;
  logic [DW-1:0] rsp_rdata;
  logic [1:0] rsp_cause;
  logic [NPHY-1:0] phy_sel, phy_wr_en, phy_rd_en, phy_ack;
  logic [AW-1:0] phy_addr;
  logic [DW-1:0] phy_wdata;
  logic [NPHY*DW-1:0] phy_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_cr_master dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout), .rsp_cause(rsp_cause),
    .phy_sel(phy_sel), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_wr_en(phy_wr_en), .phy_rd_en(phy_rd_en), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  // ---------------- PHY model ----------------
  int rise_dly = 3, fall_dly = 2;
  logic no_rise = 1'b0, no_fall = 1'b0;
  logic [DW-1:0] mem [NPHY][16];
  int cnt [NPHY];
  int sel_age [NPHY];
  logic [NPHY-1:0] en_d;
  int order_bad = 0;
  logic [AW-1:0] seen_addr;
  logic [DW-1:0] seen_wdata;
  logic [AW-1:0] addr_d1, addr_d2;
  logic [DW-1:0] wdata_d1;

  always @(posedge clk) begin
    if (rst) begin
      phy_ack <= '0; phy_rdata <= '0; en_d <= '0;
      for (int p = 0; p < NPHY; p++) begin
        cnt[p] <= 0; sel_age[p] <= 0;
        for (int a = 0; a < 16; a++) mem[p][a] <= DW'(16'hA000 + p*16 + a);
      end
    end else begin
      addr_d1 <= phy_addr; addr_d2 <= addr_d1; wdata_d1 <= phy_wdata;
      for (int p = 0; p < NPHY; p++) begin
        en_d[p] <= phy_wr_en[p] | phy_rd_en[p];
        sel_age[p] <= phy_sel[p] ? sel_age[p] + 1 : 0;
        if ((phy_wr_en[p] | phy_rd_en[p]) && !en_d[p]) begin
          seen_addr  <= phy_addr;
          seen_wdata <= phy_wdata;
          // R9: select settled; R2: write data changed after the address
          if (!phy_sel[p] || sel_age[p] < GAP) order_bad <= order_bad + 1;
          if (phy_wr_en[p] && (phy_wdata != wdata_d1) && (addr_d2 == phy_addr))
            order_bad <= order_bad + 1;
        end
        if (!phy_ack[p]) begin
          if ((phy_wr_en[p] | phy_rd_en[p]) && !no_rise) begin
            if (cnt[p] >= rise_dly) begin
              phy_ack[p] <= 1'b1; cnt[p] <= 0;
              if (phy_wr_en[p]) mem[p][phy_addr[3:0]] <= phy_wdata;
              else phy_rdata[p*DW +: DW] <= mem[p][phy_addr[3:0]];
            end else cnt[p] <= cnt[p] + 1;
          end else cnt[p] <= 0;
        end else begin
          if (!(phy_wr_en[p] | phy_rd_en[p]) && !no_fall) begin
            if (cnt[p] >= fall_dly) begin phy_ack[p] <= 1'b0; cnt[p] <= 0; end
            else cnt[p] <= cnt[p] + 1;
          end else cnt[p] <= 0;
        end
      end
    end
  end

  // ---------------- checking ----------------
  int total = 0, bad = 0, cyc = 0;
  logic [DW-1:0] got_rdata;
  logic got_to;
  logic [1:0] got_cause;
  logic got_en_clear;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic start_cmd(input logic w, input logic p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_phy = p; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!rsp_done && n < 3000) begin @(negedge clk); n++; end
    got_rdata = rsp_rdata; got_to = rsp_timeout; got_cause = rsp_cause;
    got_en_clear = ((phy_wr_en | phy_rd_en) == '0);
  endtask

  task automatic do_cmd(input logic w, input logic p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    start_cmd(w, p, a, d);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cmd_ready && !rsp_done && !rsp_timeout && rsp_cause == 2'b00 &&
          phy_sel == '0 && phy_wr_en == '0 && phy_rd_en == '0, "R1 reset state",
          {phy_sel, phy_wr_en, phy_rd_en, cmd_ready}, 32'h1);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready && phy_sel == '0, "R1 after reset", {phy_sel, cmd_ready}, 32'h1);

    // Vector table: R3 writes, R4 reads, R11 per-PHY routing
    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      do_cmd(v[VW-1], v[VW-2], v[2*DW +: AW], v[DW +: DW]);
      check(!got_to, "R5 no timeout in vector", {31'b0, got_to}, 32'h0);
      if (v[VW-1]) begin
        check(seen_addr == v[2*DW +: AW] && seen_wdata == v[DW +: DW], "R3 R2 write bus at enable",
              {seen_addr, seen_wdata}, {v[2*DW +: AW], v[DW +: DW]});
      end else begin
        check(got_rdata == v[DW-1:0], "R4 R11 read data", got_rdata, v[DW-1:0]);
      end
      check(got_en_clear, "R8 enables low at done", {31'b0, got_en_clear}, 32'h1);
      @(negedge clk);
      check(!rsp_done, "R12 done one cycle", {31'b0, rsp_done}, 32'h0);
    end
    // R9: both selects up and held
    check(phy_sel == 2'b11, "R9 selects sticky", {30'b0, phy_sel}, 32'h3);

    // R5: slow acknowledge within budget
    rise_dly = 120;
    do_cmd(1'b0, 1'b0, 16'h0003, 16'h0);
    check(!got_to && got_rdata == 16'h1111, "R5 late ack in budget", {got_to, got_rdata}, {1'b0, 16'h1111});
    rise_dly = 3;

    // R6: rise timeouts for write and read
    no_rise = 1'b1;
    do_cmd(1'b1, 1'b0, 16'h0004, 16'h5555);
    check(got_to && got_cause == 2'b10, "R6 write rise timeout", {got_to, got_cause}, 3'b110);
    check(got_en_clear, "R8 enable dropped on timeout", {31'b0, got_en_clear}, 32'h1);
    do_cmd(1'b0, 1'b1, 16'h0004, 16'h0);
    check(got_to && got_cause == 2'b00, "R6 read rise timeout", {got_to, got_cause}, 3'b100);
    repeat (5) @(negedge clk);
    check(rsp_timeout && rsp_cause == 2'b00, "R12 timeout held", {rsp_timeout, rsp_cause}, 3'b100);
    no_rise = 1'b0;

    // R7: fall timeouts
    no_fall = 1'b1;
    do_cmd(1'b1, 1'b0, 16'h0006, 16'h6666);
    check(got_to && got_cause == 2'b11, "R7 write fall timeout", {got_to, got_cause}, 3'b111);
    no_fall = 1'b0; repeat (10) @(negedge clk);
    no_fall = 1'b1;
    do_cmd(1'b0, 1'b0, 16'h0006, 16'h0);
    check(got_to && got_cause == 2'b01 && got_rdata == 16'h6666, "R7 read fall timeout",
          {got_to, got_cause, got_rdata}, {3'b101, 16'h6666});
    no_fall = 1'b0; repeat (10) @(negedge clk);

    // Recovery and R6 proof that the rise-timed-out write stored nothing
    do_cmd(1'b0, 1'b0, 16'h0004, 16'h0);
    check(!got_to && got_rdata == 16'hA004, "R6 recovery read", {got_to, got_rdata}, {1'b0, 16'hA004});

    // R10: command offered while busy is dropped
    rise_dly = 60;
    start_cmd(1'b1, 1'b0, 16'h0008, 16'h7777);
    repeat (4) @(negedge clk);
    check(!cmd_ready, "R10 not ready while busy", {31'b0, cmd_ready}, 32'h0);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_phy = 1'b0; cmd_addr = 16'h0009; cmd_wdata = 16'hDEAD;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    rise_dly = 3;
    check(!got_to, "R10 busy write completes", {31'b0, got_to}, 32'h0);
    @(negedge clk);
    check(cmd_ready, "R10 ready when idle", {31'b0, cmd_ready}, 32'h1);
    do_cmd(1'b0, 1'b0, 16'h0009, 16'h0);
    check(got_rdata == 16'hA009, "R10 dropped command no effect", got_rdata, 16'hA009);
    do_cmd(1'b0, 1'b0, 16'h0008, 16'h0);
    check(got_rdata == 16'h7777, "R3 accepted busy-case write stored", got_rdata, 16'h7777);

    // R2 R9: ordering and settle observed by the PHY model
    check(order_bad == 0, "R2 R9 order at enable", order_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule